// File: doc/BRIEF.md
# Eight-Channel Compare Waveform Generator

The block drives eight digital waveform pins from one shared 16-bit up-counting base timer. The timer advances once per cycle in which the tick input is high. Each channel compares the timer with its own active compare value. Its control byte then decides how a match moves the pin: a one-shot level change per timer period, a toggle, or a set/reset pair formed with the neighbouring odd channel. A final inversion stage sits in front of every pin.

Compare values are double-buffered. A channel can apply a written value at once, or hold it in a buffer until the next base-timer reset. Channel 0's control byte also holds a global early-reset option. With it set, the timer clears on every carry out of bit 9, which gives a 1024-tick period. Software writes control bytes and compare values through one write port and can read any channel's control byte back.

Top module: `wg_top`

## Requirements
- R1: The base timer starts at 0, increments by one on each clock with tick_i high, holds while tick_i is low, and wraps from 0xFFFF to 0. A wrap is a timer reset event.
- R2: When bit 7 of channel 0's control byte is 1, a tick taken while timer bits [9:0] are all ones clears the whole timer to 0, counted from any timer value. That tick is a timer reset event. Bit 7 of channels 1 to 7 always reads 0 and ignores writes.
- R3: The control byte is {early[7], enable[6], reload_on_reset[5], invert[4], init_level[3], mode[2:0]}. rd_ctrl_o returns the stored byte of channel rd_ch_i.
- R4: While a channel's enable bit is 0, its pin equals init_level XOR invert, whatever the timer and compare values are.
- R5: In mode 000 (single), the pin moves to the non-initial level after the tick on which the timer equals the active compare value. It returns to the initial level after each timer reset event.
- R6: In mode 010 (phase), the internal level toggles after each tick on which the timer equals the active compare value.
- R7: In mode 001 on an even channel (set/reset), a match on that channel drives the non-initial level. A match on the next odd channel, or a timer reset event, restores the initial level. While paired this way, the odd channel's pin is 0 and writes to its mode field are ignored.
- R8: Modes 011 to 111, and mode 001 on an odd channel, take no action: an enabled channel holds its initial level.
- R9: With reload_on_reset 0, a compare write takes effect for the next tick. With 1, the written value goes to a buffer and becomes active only on the next timer reset event.
- R10: Writing the enable bit from 0 to 1 copies the buffered compare value into the active compare register and sets the internal level to the written init_level.
- R11: When a match and a timer reset event fall on the same tick, the reset action wins: single mode ends at the initial level and phase mode does not toggle.
- R12: After reset, all pins are 0, all control bytes are 0 and the timer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timer count enable |
| ctrl_we_i | input | 1 | Write wr_data_i[7:0] to the control byte of wr_ch_i |
| cmp_we_i | input | 1 | Write wr_data_i to the compare value of wr_ch_i |
| wr_ch_i | input | 3 | Channel addressed by a write |
| wr_data_i | input | 16 | Write data |
| rd_ch_i | input | 3 | Channel whose control byte is read |
| rd_ctrl_o | output | 8 | Stored control byte of rd_ch_i |
| timer_o | output | 16 | Base timer value |
| wave_o | output | 8 | Waveform pins, one per channel |

## Verification
The bench aims at ticks where a match and a timer reset coincide (compare value 1023 in early mode). A design that let the match win would leave single mode at the wrong level and would toggle phase mode once too often. It checks the exact tick on which a pin moves, one tick before and one tick after the match, so an off-by-one comparator shows up. It turns on early reset while the timer is already above 1023, which exposes a design that compares the full counter instead of the carry from bit 9. It also checks buffered compare writes, enable-time reload and ignored mode writes to a paired odd channel: a design that applied a buffered value too early, skipped the reload on enable or let the odd channel's mode change would move the pin at the wrong timer value or read back a different byte.

// File: rtl/wg_pkg.sv
`timescale 1ns/1ps
package wg_pkg;
  localparam int CTRL_W = 8;

  localparam logic [2:0] MODE_SINGLE = 3'b000;
  localparam logic [2:0] MODE_SR     = 3'b001;
  localparam logic [2:0] MODE_PHASE  = 3'b010;

  typedef struct packed {
    logic       early;
    logic       en;
    logic       reload;
    logic       inv;
    logic       init;
    logic [2:0] mode;
  } ctrl_t;
endpackage

// File: rtl/wg_timer.sv
`timescale 1ns/1ps
module wg_timer #(
  parameter int TW = 16,
  parameter int EW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          early_i,
  output logic [TW-1:0] cnt_o,
  output logic          rst_evt_o
);
  logic [TW-1:0] cnt_q;

  // early mode: carry out of bit EW-1 clears the whole counter
  assign rst_evt_o = tick_i && (early_i ? (&cnt_q[EW-1:0]) : (&cnt_q));
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (rst_evt_o) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wg_channel.sv
`timescale 1ns/1ps
module wg_channel
  import wg_pkg::*;
#(
  parameter int TW        = 16,
  parameter bit HAS_EARLY = 1'b0,
  parameter bit IS_EVEN   = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          tmr_rst_i,
  input  logic [TW-1:0] timer_i,
  input  logic          ctrl_we_i,
  input  logic          cmp_we_i,
  input  logic [TW-1:0] wr_data_i,
  input  logic          peer_match_i,
  input  logic          peer_sr_i,
  output ctrl_t         ctrl_o,
  output logic          match_o,
  output logic          sr_o,
  output logic          wave_o
);
  ctrl_t         ctrl_q, wr_c, ctrl_d;
  logic [TW-1:0] buf_q, act_q;
  logic          state_q, en_rise, lvl;

  assign wr_c    = ctrl_t'(wr_data_i[CTRL_W-1:0]);
  assign en_rise = ctrl_we_i && wr_c.en && !ctrl_q.en;
  assign match_o = tick_i && (timer_i == act_q);
  assign sr_o    = IS_EVEN && (ctrl_q.mode == MODE_SR);
  assign ctrl_o  = ctrl_q;

  always_comb begin
    ctrl_d = wr_c;
    if (!HAS_EARLY) ctrl_d.early = 1'b0;
    if (peer_sr_i)  ctrl_d.mode  = ctrl_q.mode;  // paired odd keeps its mode
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (cmp_we_i) buf_q <= wr_data_i;
      if (cmp_we_i && !ctrl_q.reload)                act_q <= wr_data_i;
      else if (en_rise || (tmr_rst_i && ctrl_q.reload)) act_q <= buf_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= 1'b0;
    else if (!ctrl_q.en) state_q <= en_rise ? wr_c.init : ctrl_q.init;
    else begin
      case (ctrl_q.mode)
        MODE_SINGLE: begin
          if (tmr_rst_i)    state_q <= ctrl_q.init;
          else if (match_o) state_q <= !ctrl_q.init;
        end
        MODE_SR: begin
          if (!IS_EVEN)                      state_q <= ctrl_q.init;
          else if (tmr_rst_i || peer_match_i) state_q <= ctrl_q.init;
          else if (match_o)                  state_q <= !ctrl_q.init;
        end
        MODE_PHASE: begin
          if (match_o && !tmr_rst_i) state_q <= !state_q;
        end
        default: state_q <= ctrl_q.init;
      endcase
    end
  end

  assign lvl    = ctrl_q.en ? state_q : ctrl_q.init;
  assign wave_o = peer_sr_i ? 1'b0 : (lvl ^ ctrl_q.inv);
endmodule

// File: rtl/wg_top.sv
`timescale 1ns/1ps
module wg_top
  import wg_pkg::*;
#(
  parameter int NCH = 8,
  parameter int TW  = 16,
  parameter int EW  = 10,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ctrl_we_i,
  input  logic              cmp_we_i,
  input  logic [CHW-1:0]    wr_ch_i,
  input  logic [TW-1:0]     wr_data_i,
  input  logic [CHW-1:0]    rd_ch_i,
  output logic [CTRL_W-1:0] rd_ctrl_o,
  output logic [TW-1:0]     timer_o,
  output logic [NCH-1:0]    wave_o
);
  ctrl_t [NCH-1:0] ctrl_all;
  logic  [NCH-1:0] match, sr;
  logic            tmr_rst;

  wg_timer #(.TW(TW), .EW(EW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .early_i   (ctrl_all[0].early),
    .cnt_o     (timer_o),
    .rst_evt_o (tmr_rst)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam bit EVEN = (ch % 2) == 0;
    logic pm, ps;
    if (EVEN) begin : g_even
      assign pm = match[ch+1];
      assign ps = 1'b0;
    end else begin : g_odd
      assign pm = 1'b0;
      assign ps = sr[ch-1];
    end
    wg_channel #(.TW(TW), .HAS_EARLY(ch == 0), .IS_EVEN(EVEN)) u_ch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tick_i       (tick_i),
      .tmr_rst_i    (tmr_rst),
      .timer_i      (timer_o),
      .ctrl_we_i    (ctrl_we_i && (wr_ch_i == CHW'(ch))),
      .cmp_we_i     (cmp_we_i && (wr_ch_i == CHW'(ch))),
      .wr_data_i    (wr_data_i),
      .peer_match_i (pm),
      .peer_sr_i    (ps),
      .ctrl_o       (ctrl_all[ch]),
      .match_o      (match[ch]),
      .sr_o         (sr[ch]),
      .wave_o       (wave_o[ch])
    );
  end

  assign rd_ctrl_o = ctrl_all[rd_ch_i];
endmodule

// File: rtl/wg_checker.sv
`timescale 1ns/1ps
module wg_checker
  import wg_pkg::*;
#(
  parameter int NCH = 8,
  parameter int TW  = 16,
  parameter int EW  = 10
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      tick_i,
  input logic                      ctrl_we_i,
  input logic [TW-1:0]             timer_o,
  input logic [NCH-1:0]            wave_o,
  input logic [NCH-1:0][CTRL_W-1:0] ctrl_all,
  input logic [NCH-1:0]            match,
  input logic [NCH-1:0]            sr,
  input logic                      tmr_rst
);
  ctrl_t c0;
  assign c0 = ctrl_t'(ctrl_all[0]);

  p_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !tmr_rst) |=> timer_o == TW'($past(timer_o) + 1'b1));

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(timer_o));

  p_early_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c0.early && tick_i && (&timer_o[EW-1:0])) |=> timer_o == '0);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    ctrl_t c;
    logic  paired;
    assign c = ctrl_t'(ctrl_all[ch]);
    if ((ch % 2) == 1) begin : g_odd
      assign paired = sr[ch-1];
    end else begin : g_even
      assign paired = 1'b0;
    end

    p_disabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!c.en && !paired) |-> wave_o[ch] == (c.init ^ c.inv));

    p_odd_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      paired |-> !wave_o[ch]);

    // R11: reset wins over a same-tick match
    p_single_reset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c.en && !paired && c.mode == MODE_SINGLE && tmr_rst && !ctrl_we_i)
        |=> wave_o[ch] == (c.init ^ c.inv));

    p_phase_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c.en && !paired && c.mode == MODE_PHASE && match[ch] && !tmr_rst && !ctrl_we_i)
        |=> wave_o[ch] != $past(wave_o[ch]));
  end
endmodule

bind wg_top wg_checker #(.NCH(NCH), .TW(TW), .EW(EW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .ctrl_we_i (ctrl_we_i),
  .timer_o   (timer_o),
  .wave_o    (wave_o),
  .ctrl_all  (ctrl_all),
  .match     (match),
  .sr        (sr),
  .tmr_rst   (tmr_rst)
);

// File: tb/tb_wg_top.sv
`timescale 1ns/1ps
module tb_wg_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic        cmp_we_i = 1'b0;
  logic [2:0]  wr_ch_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [2:0]  rd_ch_i = '0;
  logic [7:0]  rd_ctrl_o;
  logic [15:0] timer_o;
  logic [7:0]  wave_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  wg_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .ctrl_we_i(ctrl_we_i), .cmp_we_i(cmp_we_i), .wr_ch_i(wr_ch_i),
    .wr_data_i(wr_data_i), .rd_ch_i(rd_ch_i), .rd_ctrl_o(rd_ctrl_o),
    .timer_o(timer_o), .wave_o(wave_o)
  );

  // mode, init, inv, cmp, ticks  (channel 2, early reset on)
  localparam int NV = 13;
  localparam int VEC [NV][5] = '{
    '{0, 0, 0, 100,   50},
    '{0, 0, 0, 100,  100},
    '{0, 0, 0, 100,  101},
    '{0, 1, 0, 100,  200},
    '{0, 0, 1, 500,  600},
    '{0, 0, 0, 100, 1030},
    '{0, 0, 0, 1023, 1024},
    '{2, 0, 0, 10,     11},
    '{2, 0, 0, 10,   1035},
    '{2, 1, 1, 10,   2060},
    '{2, 0, 0, 1023, 2048},
    '{3, 0, 0, 5,     100},
    '{5, 1, 0, 5,     100}
  };

  function automatic logic [7:0] mk(bit early, bit en, bit rl, bit inv, bit init, logic [2:0] mode);
    return {early, en, rl, inv, init, mode};
  endfunction

  function automatic int model(int mode, int init, int inv, int cmp, int n);
    int s = init;
    for (int k = 0; k < n; k++) begin
      int t = k % 1024;
      bit rst = (t == 1023);
      bit m = (t == cmp);
      if (mode == 0) begin
        if (rst) s = init; else if (m) s = 1 - init;
      end else if (mode == 2) begin
        if (m && !rst) s = 1 - s;
      end else s = init;
    end
    return s ^ inv;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    tick_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr_ctrl(int ch, logic [7:0] d);
    @(negedge clk_i);
    ctrl_we_i = 1'b1; wr_ch_i = 3'(ch); wr_data_i = {8'h00, d};
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  task automatic wr_cmp(int ch, int v);
    @(negedge clk_i);
    cmp_we_i = 1'b1; wr_ch_i = 3'(ch); wr_data_i = 16'(v);
    @(negedge clk_i);
    cmp_we_i = 1'b0;
  endtask

  task automatic run(int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    do_reset();
    check("R12 wave", int'(wave_o), 0);
    check("R12 timer", int'(timer_o), 0);
    rd_ch_i = 3'd5; #1;
    check("R12 ctrl", int'(rd_ctrl_o), 0);

    // R3 / R2 readback
    wr_ctrl(3, 8'hFF);
    rd_ch_i = 3'd3; #1;
    check("R2 bit7 ch3", int'(rd_ctrl_o), 8'h7F);
    wr_ctrl(0, 8'hFF);
    rd_ch_i = 3'd0; #1;
    check("R3 ch0", int'(rd_ctrl_o), 8'hFF);

    // R1 count, hold, wrap
    do_reset();
    run(5);
    check("R1 count", int'(timer_o), 5);
    repeat (4) @(negedge clk_i);
    check("R1 hold", int'(timer_o), 5);
    run(65531);
    check("R1 wrap", int'(timer_o), 0);

    // R2 early clear, from zero and from above 1023
    do_reset();
    wr_ctrl(0, mk(1, 0, 0, 0, 0, 3'd0));
    run(1023);
    check("R2 top", int'(timer_o), 1023);
    run(1);
    check("R2 clear", int'(timer_o), 0);
    do_reset();
    run(2000);
    wr_ctrl(0, mk(1, 0, 0, 0, 0, 3'd0));
    run(47);
    check("R2 high before", int'(timer_o), 2047);
    run(1);
    check("R2 high clear", int'(timer_o), 0);

    // vector table: R5 R6 R8 R11
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = (VEC[i][3] == 1023) ? "R11" : (VEC[i][0] == 0) ? "R5" : (VEC[i][0] == 2) ? "R6" : "R8";
      do_reset();
      wr_ctrl(0, mk(1, 0, 0, 0, 0, 3'd0));
      wr_cmp(2, VEC[i][3]);
      wr_ctrl(2, mk(0, 1, 0, VEC[i][2][0], VEC[i][1][0], 3'(VEC[i][0])));
      run(VEC[i][4]);
      check($sformatf("%s vec%0d", tag, i), int'(wave_o[2]),
            model(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]));
    end

    // R8 set/reset code on an odd channel is inert
    do_reset();
    wr_ctrl(0, mk(1, 0, 0, 0, 0, 3'd0));
    wr_cmp(5, 3);
    wr_ctrl(5, mk(0, 1, 0, 0, 1, 3'd1));
    run(20);
    check("R8 odd sr", int'(wave_o[5]), 1);

    // R4 disabled channel
    do_reset();
    wr_cmp(6, 3);
    wr_ctrl(6, mk(0, 0, 0, 0, 1, 3'd0));
    run(10);
    check("R4 init1", int'(wave_o[6]), 1);
    wr_ctrl(6, mk(0, 0, 0, 1, 1, 3'd0));
    check("R4 init1 inv", int'(wave_o[6]), 0);
    wr_ctrl(6, mk(0, 0, 0, 1, 0, 3'd2));
    check("R4 init0 inv", int'(wave_o[6]), 1);

    // R7 set/reset pair on channels 2 and 3
    do_reset();
    wr_ctrl(0, mk(1, 0, 0, 0, 0, 3'd0));
    wr_ctrl(3, 8'h40);
    wr_cmp(3, 300);
    wr_cmp(2, 100);
    wr_ctrl(2, mk(0, 1, 0, 0, 0, 3'd1));
    wr_ctrl(3, 8'h42);
    rd_ch_i = 3'd3; #1;
    check("R7 odd mode kept", int'(rd_ctrl_o), 8'h40);
    run(50);
    check("R7 before set", int'(wave_o[2]), 0);
    run(151);
    check("R7 set", int'(wave_o[2]), 1);
    check("R7 odd pin", int'(wave_o[3]), 0);
    run(200);
    check("R7 cleared", int'(wave_o[2]), 0);
    check("R7 odd pin late", int'(wave_o[3]), 0);

    // R9 buffered (ch1) vs immediate (ch4) reload
    do_reset();
    wr_ctrl(0, mk(1, 0, 0, 0, 0, 3'd0));
    wr_cmp(1, 100);
    wr_cmp(4, 100);
    wr_ctrl(1, mk(0, 1, 1, 0, 0, 3'd0));
    wr_ctrl(4, mk(0, 1, 0, 0, 0, 3'd0));
    run(50);
    wr_cmp(1, 600);
    wr_cmp(4, 600);
    run(150);
    check("R9 buffered old", int'(wave_o[1]), 1);
    check("R9 immediate new", int'(wave_o[4]), 0);
    run(1124);
    check("R9 buffered after reset", int'(wave_o[1]), 0);
    run(400);
    check("R9 buffered new", int'(wave_o[1]), 1);
    check("R9 immediate", int'(wave_o[4]), 1);

    // R10 enable copies buffer and restores init
    do_reset();
    wr_ctrl(0, mk(1, 0, 0, 0, 0, 3'd0));
    wr_ctrl(5, mk(0, 0, 1, 0, 1, 3'd0));
    wr_cmp(5, 10);
    run(5);
    check("R4 ch5 disabled", int'(wave_o[5]), 1);
    wr_ctrl(5, mk(0, 1, 1, 0, 1, 3'd0));
    check("R10 init on enable", int'(wave_o[5]), 1);
    run(6);
    check("R10 reloaded", int'(wave_o[5]), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule